// File: doc/BRIEF.md
# Speculative Store Buffer with Atomic Group Commit

This block sits between a core's store path and its first-level cache. While a lock-free (elided) critical section runs, the core sends its stores here marked as speculative. The block keeps them out of the cache, so no other agent sees them. A later store to a word that is already held is folded into the existing entry, byte by byte. As soon as a store opens a cache line not yet held, the block asks the coherence controller for exclusive ownership of that line. Ownership is therefore usually in place by the time the section ends.

When the core validates the section, the block waits until every held line is owned. It then streams all entries to the cache as one unbroken group. Coherence snoops are held off for the whole drain, so the group becomes visible as a unit. An explicit abort discards everything in one edge. The block discards on its own, and reports a misspeculation with a cause code, in two cases: a speculative store finds no free entry, or an accepted snoop touches a held line. When the buffer is empty and no commit is pending, a store not marked speculative passes straight through to the cache port.

The store input, the drain port and the snoop input use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. A source holds valid and its payload stable until that edge. The commit, abort, ownership-request, grant, misspeculation and commit-done pins are plain single-cycle pulses.

Top module: `swb_top`

## Requirements
- R1: A speculative store that is accepted never appears on the drain port before a commit has been requested and its ownership wait has ended.
- R2: A non-speculative store passes through to the drain port in the same cycle, with `dr_last` high, only when the buffer is empty and the state is running. In that case `st_ready` follows `dr_ready`. While any entry is held, a non-speculative store sees `st_ready` low and nothing is driven on the drain port.
- R3: A speculative store to a word address that is already held updates only the bytes whose strobe bits are set (strobe bit b covers data bits 8b+7..8b). It ORs its strobe into the entry and takes no new entry, so the drain carries one beat with the merged bytes.
- R4: `req_x_valid` pulses in the cycle after a speculative store is accepted, with `req_x_line` = address >> 2, but only if no held entry already lies in that line. Merges and further stores to a held line raise no request.
- R5: After a commit request, the drain does not start until every held entry has been marked owned. A grant marks every held entry whose line matches `gnt_line`, and an entry allocated later in an owned line is born owned. Once all entries are owned, the first drain beat is valid after the next rising edge.
- R6: The drain emits entries in allocation order, one per accepted beat. `dr_last` is high only on the final beat. The address, data and strobe hold stable while `dr_ready` is low. `commit_done` pulses in the cycle after the final beat. A commit with an empty buffer pulses `commit_done` in the cycle after the request, with no beats.
- R7: A speculative store to a new word when all DEPTH entries are held is consumed and dropped. All entries are discarded, and in the next cycle `miss_valid` pulses with `miss_cause` = 0 (no room). A merge into a full buffer is not an overflow.
- R8: `spec_abort` discards every entry on a single edge while running or waiting for ownership. A later commit then completes empty and no misspeculation is reported. During a drain, abort is ignored and the whole group still drains.
- R9: `snp_ready` is low for the whole drain. An accepted snoop whose line matches a held entry discards all entries, and `miss_valid` pulses in the next cycle with `miss_cause` = 1 (conflict). A snoop to an unheld line has no effect.
- R10: While a commit waits for ownership, and in any cycle with `spec_commit` or `spec_abort` high, `st_ready` is low for speculative stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle |
| st_spec | input | 1 | Store belongs to a speculative section |
| st_addr | input | AW (16) | Word address of the store |
| st_data | input | DW (32) | Store data |
| st_strb | input | DW/8 (4) | Byte strobe of the store |
| spec_commit | input | 1 | Pulse: validate the section and commit |
| spec_abort | input | 1 | Pulse: discard the section |
| commit_done | output | 1 | Pulse: commit group fully drained |
| miss_valid | output | 1 | Pulse: block-detected misspeculation |
| miss_cause | output | 1 | 0 = no free entry, 1 = snoop conflict |
| req_x_valid | output | 1 | Pulse: request exclusive ownership |
| req_x_line | output | AW-2 (14) | Line of the ownership request |
| gnt_valid | input | 1 | Pulse: exclusive ownership granted |
| gnt_line | input | AW-2 (14) | Line that was granted |
| snp_valid | input | 1 | Incoming snoop valid |
| snp_ready | output | 1 | Snoop accepted this cycle |
| snp_line | input | AW-2 (14) | Line of the snoop |
| dr_valid | output | 1 | Drain beat valid toward the cache |
| dr_ready | input | 1 | Cache accepts the drain beat |
| dr_addr | output | AW (16) | Drain word address |
| dr_data | output | DW (32) | Drain data |
| dr_strb | output | DW/8 (4) | Drain byte strobe |
| dr_last | output | 1 | Final beat of the group |

## Verification
The bench drives and samples on the falling edge. Combinational results are read at the falling edge where their inputs are driven: `st_ready`, `snp_ready` and bypass beats. Registered pulses are read at the falling edge just after the rising edge that causes them, which is one cycle later: `req_x_valid`, `miss_valid` and `commit_done`. The first drain beat is due two rising edges after the commit request when all lines are already owned. Otherwise it is due on the edge after the grant that completes ownership. The bench counts cycles explicitly to confirm that `commit_done` follows the final beat by exactly one cycle. While the drain is back-pressured, it compares each held beat against the one seen in the previous cycle.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } swb_state_e;

  typedef enum logic {
    MISS_FULL     = 1'b0,
    MISS_CONFLICT = 1'b1
  } swb_miss_e;
endpackage

// File: rtl/swb_entries.sv
module swb_entries #(
  parameter int DEPTH      = 4,
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_SHIFT = 2,
  localparam int SW = DW / 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = AW - LINE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          alloc_i,
  input  logic [IW-1:0] alloc_idx_i,
  input  logic          merge_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [SW-1:0] wr_strb_i,
  input  logic          gnt_valid_i,
  input  logic [LW-1:0] gnt_line_i,
  input  logic [LW-1:0] snp_line_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          hit_o,
  output logic          line_hit_o,
  output logic          snp_hit_o,
  output logic          all_owned_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_data_o,
  output logic [SW-1:0] rd_strb_o
);
  logic [AW-1:0]    addr_w [DEPTH];
  logic [DW-1:0]    data_w [DEPTH];
  logic [SW-1:0]    strb_w [DEPTH];
  logic [DEPTH-1:0] vld_w, own_w, hit_v, lhit_v, snp_v;
  logic [IW-1:0]    hit_idx;
  logic [LW-1:0]    wr_line;
  logic             new_own;

  assign wr_line = wr_addr_i[AW-1:LINE_SHIFT];
  // an entry joining a line that is already owned, or granted this cycle, starts owned
  assign new_own = (|(lhit_v & own_w)) || (gnt_valid_i && (gnt_line_i == wr_line));

  always_comb begin
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit_v[k]) hit_idx = IW'(k);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [SW-1:0] s_q;
    logic          v_q;
    logic          o_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        d_q <= '0;
        s_q <= '0;
        v_q <= 1'b0;
        o_q <= 1'b0;
      end else if (clear_i) begin
        v_q <= 1'b0;
        o_q <= 1'b0;
      end else if (alloc_i && (alloc_idx_i == IW'(i))) begin
        v_q <= 1'b1;
        a_q <= wr_addr_i;
        d_q <= wr_data_i;
        s_q <= wr_strb_i;
        o_q <= new_own;
      end else begin
        if (merge_i && (hit_idx == IW'(i))) begin
          for (int b = 0; b < SW; b++) begin
            if (wr_strb_i[b]) d_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
          end
          s_q <= s_q | wr_strb_i;
        end
        if (v_q && gnt_valid_i && (a_q[AW-1:LINE_SHIFT] == gnt_line_i)) o_q <= 1'b1;
      end
    end

    assign addr_w[i] = a_q;
    assign data_w[i] = d_q;
    assign strb_w[i] = s_q;
    assign vld_w[i]  = v_q;
    assign own_w[i]  = o_q;
    assign hit_v[i]  = v_q && (a_q == wr_addr_i);
    assign lhit_v[i] = v_q && (a_q[AW-1:LINE_SHIFT] == wr_line);
    assign snp_v[i]  = v_q && (a_q[AW-1:LINE_SHIFT] == snp_line_i);
  end

  assign hit_o       = |hit_v;
  assign line_hit_o  = |lhit_v;
  assign snp_hit_o   = |snp_v;
  assign all_owned_o = &(own_w | ~vld_w);
  assign rd_addr_o   = addr_w[rd_idx_i];
  assign rd_data_o   = data_w[rd_idx_i];
  assign rd_strb_o   = strb_w[rd_idx_i];
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = 14,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic          abort_i,
  input  logic          st_fire_i,
  input  logic          st_hit_i,
  input  logic          line_hit_i,
  input  logic [LW-1:0] st_line_i,
  input  logic          snp_fire_i,
  input  logic          snp_hit_i,
  input  logic          all_owned_i,
  input  logic          dr_ready_i,
  output swb_state_e    state_o,
  output logic [CW-1:0] count_o,
  output logic [IW-1:0] ptr_o,
  output logic          last_o,
  output logic          alloc_o,
  output logic [IW-1:0] alloc_idx_o,
  output logic          merge_o,
  output logic          clear_o,
  output logic          req_valid_o,
  output logic [LW-1:0] req_line_o,
  output logic          miss_valid_o,
  output logic          miss_cause_o,
  output logic          done_o
);
  swb_state_e    state_q, state_n;
  logic [CW-1:0] count_q, count_n;
  logic [IW-1:0] ptr_q, ptr_n;
  logic          full, conflict, overflow;
  logic          miss_n, done_n;
  swb_miss_e     cause_n;

  assign full     = (count_q == CW'(DEPTH));
  assign conflict = snp_fire_i && snp_hit_i;
  assign overflow = st_fire_i && !st_hit_i && full;
  assign last_o   = ((CW'(ptr_q) + CW'(1)) == count_q);

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    clear_o = 1'b0;
    miss_n  = 1'b0;
    cause_n = MISS_FULL;
    done_n  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (abort_i) begin
          clear_o = 1'b1;
        end else if (conflict) begin
          clear_o = 1'b1;
          miss_n  = 1'b1;
          cause_n = MISS_CONFLICT;
        end else if (overflow) begin
          clear_o = 1'b1;
          miss_n  = 1'b1;
          cause_n = MISS_FULL;
        end else if (commit_i) begin
          if (count_q == '0) done_n = 1'b1;
          else state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (abort_i) begin
          clear_o = 1'b1;
          state_n = ST_RUN;
        end else if (conflict) begin
          clear_o = 1'b1;
          miss_n  = 1'b1;
          cause_n = MISS_CONFLICT;
          state_n = ST_RUN;
        end else if (all_owned_i) begin
          state_n = ST_DRAIN;
          ptr_n   = '0;
        end
      end
      ST_DRAIN: begin
        if (dr_ready_i) begin
          if (last_o) begin
            clear_o = 1'b1;
            done_n  = 1'b1;
            state_n = ST_RUN;
          end else begin
            ptr_n = ptr_q + IW'(1);
          end
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  assign alloc_o     = st_fire_i && !st_hit_i && !full && !clear_o;
  assign merge_o     = st_fire_i && st_hit_i && !clear_o;
  assign alloc_idx_o = count_q[IW-1:0];

  always_comb begin
    count_n = count_q;
    if (clear_o) count_n = '0;
    else if (alloc_o) count_n = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      count_q      <= '0;
      ptr_q        <= '0;
      req_valid_o  <= 1'b0;
      req_line_o   <= '0;
      miss_valid_o <= 1'b0;
      miss_cause_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      state_q      <= state_n;
      count_q      <= count_n;
      ptr_q        <= ptr_n;
      req_valid_o  <= alloc_o && !line_hit_i;
      req_line_o   <= st_line_i;
      miss_valid_o <= miss_n;
      miss_cause_o <= cause_n;
      done_o       <= done_n;
    end
  end

  assign state_o = state_q;
  assign count_o = count_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/swb_top.sv
module swb_top
  import swb_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_SHIFT = 2,
  localparam int SW = DW / 8,
  localparam int LW = AW - LINE_SHIFT,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic          st_spec,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [SW-1:0] st_strb,
  input  logic          spec_commit,
  input  logic          spec_abort,
  output logic          commit_done,
  output logic          miss_valid,
  output logic          miss_cause,
  output logic          req_x_valid,
  output logic [LW-1:0] req_x_line,
  input  logic          gnt_valid,
  input  logic [LW-1:0] gnt_line,
  input  logic          snp_valid,
  output logic          snp_ready,
  input  logic [LW-1:0] snp_line,
  output logic          dr_valid,
  input  logic          dr_ready,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  output logic [SW-1:0] dr_strb,
  output logic          dr_last
);
  swb_state_e    state;
  logic [CW-1:0] count;
  logic [IW-1:0] ptr, alloc_idx;
  logic          running, draining, buf_empty, bypass;
  logic          st_fire_spec, snp_fire;
  logic          hit, line_hit, snp_hit, all_owned, last;
  logic          alloc, merge, clear;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_strb;

  assign running   = (state == ST_RUN);
  assign draining  = (state == ST_DRAIN);
  assign buf_empty = (count == '0);

  assign st_ready     = st_spec ? (running && !spec_commit && !spec_abort)
                                : (running && buf_empty && dr_ready);
  assign st_fire_spec = st_valid && st_ready && st_spec;
  assign bypass       = st_valid && !st_spec && running && buf_empty;

  assign snp_ready = !draining;
  assign snp_fire  = snp_valid && snp_ready;

  assign dr_valid = draining || bypass;
  assign dr_addr  = draining ? rd_addr : st_addr;
  assign dr_data  = draining ? rd_data : st_data;
  assign dr_strb  = draining ? rd_strb : st_strb;
  assign dr_last  = draining ? last : 1'b1;

  swb_entries #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_SHIFT(LINE_SHIFT)
  ) i_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .alloc_i    (alloc),
    .alloc_idx_i(alloc_idx),
    .merge_i    (merge),
    .wr_addr_i  (st_addr),
    .wr_data_i  (st_data),
    .wr_strb_i  (st_strb),
    .gnt_valid_i(gnt_valid),
    .gnt_line_i (gnt_line),
    .snp_line_i (snp_line),
    .rd_idx_i   (ptr),
    .hit_o      (hit),
    .line_hit_o (line_hit),
    .snp_hit_o  (snp_hit),
    .all_owned_o(all_owned),
    .rd_addr_o  (rd_addr),
    .rd_data_o  (rd_data),
    .rd_strb_o  (rd_strb)
  );

  swb_ctrl #(
    .DEPTH(DEPTH), .LW(LW)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (spec_commit),
    .abort_i     (spec_abort),
    .st_fire_i   (st_fire_spec),
    .st_hit_i    (hit),
    .line_hit_i  (line_hit),
    .st_line_i   (st_addr[AW-1:LINE_SHIFT]),
    .snp_fire_i  (snp_fire),
    .snp_hit_i   (snp_hit),
    .all_owned_i (all_owned),
    .dr_ready_i  (dr_ready),
    .state_o     (state),
    .count_o     (count),
    .ptr_o       (ptr),
    .last_o      (last),
    .alloc_o     (alloc),
    .alloc_idx_o (alloc_idx),
    .merge_o     (merge),
    .clear_o     (clear),
    .req_valid_o (req_x_valid),
    .req_line_o  (req_x_line),
    .miss_valid_o(miss_valid),
    .miss_cause_o(miss_cause),
    .done_o      (commit_done)
  );
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          st_spec,
  input logic          dr_valid,
  input logic          dr_ready,
  input logic [AW-1:0] dr_addr,
  input logic [DW-1:0] dr_data,
  input logic          snp_ready,
  input logic          req_x_valid,
  input logic          miss_valid,
  input logic          draining,
  input logic          waiting,
  input logic          all_owned,
  input logic [CW-1:0] count
);
  p_hidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !draining) |-> !dr_valid);

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !draining) |-> (st_valid && !st_spec && count == '0));

  p_req_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_x_valid |-> $past(st_valid && st_ready && st_spec));

  p_owned_before_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> all_owned);

  p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_miss_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (count == '0));

  p_snoop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !snp_ready);

  p_stall_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && st_spec) |-> !st_ready);
endmodule

bind swb_top swb_checker #(
  .AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)
) i_swb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_spec    (st_spec),
  .dr_valid   (dr_valid),
  .dr_ready   (dr_ready),
  .dr_addr    (dr_addr),
  .dr_data    (dr_data),
  .snp_ready  (snp_ready),
  .req_x_valid(req_x_valid),
  .miss_valid (miss_valid),
  .draining   (draining),
  .waiting    (state == swb_pkg::ST_WAIT),
  .all_owned  (all_owned),
  .count      (count)
);

// File: tb/test_swb_top.sv
module test_swb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int LW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, st_spec = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [SW-1:0] st_strb = '0;
  logic          spec_commit = 1'b0, spec_abort = 1'b0;
  logic          commit_done, miss_valid, miss_cause, req_x_valid;
  logic [LW-1:0] req_x_line;
  logic          gnt_valid = 1'b0;
  logic [LW-1:0] gnt_line = '0;
  logic          snp_valid = 1'b0;
  logic          snp_ready;
  logic [LW-1:0] snp_line = '0;
  logic          dr_valid, dr_last;
  logic          dr_ready = 1'b1;
  logic [AW-1:0] dr_addr;
  logic [DW-1:0] dr_data;
  logic [SW-1:0] dr_strb;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] got_a [8];
  logic [DW-1:0] got_d [8];
  logic [SW-1:0] got_s [8];
  logic          got_l [8];
  int            got_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swb_top i_swb_top (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_spec(st_spec),
    .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
    .spec_commit(spec_commit), .spec_abort(spec_abort), .commit_done(commit_done),
    .miss_valid(miss_valid), .miss_cause(miss_cause),
    .req_x_valid(req_x_valid), .req_x_line(req_x_line),
    .gnt_valid(gnt_valid), .gnt_line(gnt_line),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_line(snp_line),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_strb(dr_strb), .dr_last(dr_last)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic spec_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
    st_valid = 1'b1; st_spec = 1'b1; st_addr = a; st_data = d; st_strb = s;
    for (int g = 0; g < 20 && !st_ready; g++) tick();
    tick();
    st_valid = 1'b0;
  endtask

  task automatic grant(input logic [LW-1:0] l);
    gnt_valid = 1'b1; gnt_line = l;
    tick();
    gnt_valid = 1'b0;
  endtask

  task automatic pulse_abort();
    spec_abort = 1'b1;
    tick();
    spec_abort = 1'b0;
  endtask

  task automatic snoop(input logic [LW-1:0] l);
    snp_valid = 1'b1; snp_line = l;
    tick();
    snp_valid = 1'b0;
  endtask

  // request commit, gather every drain beat, and check done timing (R6) and snoop hold-off (R9)
  task automatic run_commit(input bit bp);
    bit            done = 0;
    bit            held = 0;
    logic [AW-1:0] held_a = '0;
    int            last_it = -1;
    int            done_it = -1;
    got_n = 0;
    spec_commit = 1'b1;
    tick();
    spec_commit = 1'b0;
    for (int it = 0; it < 60 && !done; it++) begin
      if (commit_done) begin
        done = 1;
        done_it = it;
      end else begin
        dr_ready = bp ? it[0] : 1'b1;
        if (dr_valid) begin
          if (held) check("R6 held beat stable", dr_addr, held_a);
          check("R9 snoop held off in drain", snp_ready, 1'b0);
          if (dr_ready) begin
            if (got_n < 8) begin
              got_a[got_n] = dr_addr; got_d[got_n] = dr_data;
              got_s[got_n] = dr_strb; got_l[got_n] = dr_last;
            end
            got_n++;
            held = 0;
            last_it = it;
          end else begin
            held = 1;
            held_a = dr_addr;
          end
        end
        tick();
      end
    end
    dr_ready = 1'b1;
    check("R6 commit_done seen", done, 1'b1);
    if (got_n > 0) check("R6 done one cycle after last beat", done_it, last_it + 1);
    else check("R6 empty commit done next cycle", done_it, 0);
  endtask

  task automatic t_reset();
    check("R1 reset dr_valid", dr_valid, 1'b0);
    check("R4 reset req_x_valid", req_x_valid, 1'b0);
    check("R7 reset miss_valid", miss_valid, 1'b0);
    check("R6 reset commit_done", commit_done, 1'b0);
    check("R9 reset snp_ready", snp_ready, 1'b1);
  endtask

  task automatic t_bypass();
    st_valid = 1'b1; st_spec = 1'b0; st_addr = 16'h0100; st_data = 32'hCAFE0001; st_strb = 4'hF;
    dr_ready = 1'b1;
    #1;
    check("R2 bypass valid", dr_valid, 1'b1);
    check("R2 bypass addr", dr_addr, 16'h0100);
    check("R2 bypass last", dr_last, 1'b1);
    check("R2 bypass ready", st_ready, 1'b1);
    dr_ready = 1'b0;
    #1;
    check("R2 bypass follows dr_ready", st_ready, 1'b0);
    dr_ready = 1'b1;
    tick();
    st_valid = 1'b0;
    spec_store(16'h0200, 32'h1, 4'hF);
    st_valid = 1'b1; st_spec = 1'b0; st_addr = 16'h0300;
    #1;
    check("R2 non-spec stalled while held", st_ready, 1'b0);
    check("R2 no drain while held", dr_valid, 1'b0);
    st_valid = 1'b0;
    pulse_abort();
  endtask

  task automatic t_hidden_order();
    spec_store(16'h0010, 32'hA0A0A0A0, 4'hF);
    check("R4 req on new line", req_x_valid, 1'b1);
    check("R4 req line", req_x_line, 14'h0004);
    spec_store(16'h0011, 32'hB1B1B1B1, 4'hF);
    check("R4 no req for held line", req_x_valid, 1'b0);
    spec_store(16'h0020, 32'hC2C2C2C2, 4'hF);
    check("R4 req second line", req_x_line, 14'h0008);
    for (int k = 0; k < 3; k++) begin
      check("R1 stores hidden", dr_valid, 1'b0);
      tick();
    end
    grant(14'h0004);
    grant(14'h0008);
    run_commit(1'b0);
    check("R6 beat count", got_n, 3);
    check("R6 order 0", got_a[0], 16'h0010);
    check("R6 order 1", got_a[1], 16'h0011);
    check("R6 order 2", got_a[2], 16'h0020);
    check("R6 data 2", got_d[2], 32'hC2C2C2C2);
    check("R6 last flags", {got_l[0], got_l[1], got_l[2]}, 3'b001);
  endtask

  task automatic t_merge();
    spec_store(16'h0040, 32'h11223344, 4'b0011);
    spec_store(16'h0040, 32'hAABBCCDD, 4'b0110);
    check("R3 merge raises no request", req_x_valid, 1'b0);
    grant(14'h0010);
    run_commit(1'b0);
    check("R3 one beat", got_n, 1);
    check("R3 merged strobe", got_s[0], 4'b0111);
    check("R3 merged bytes", got_d[0] & 32'h00FFFFFF, 32'h00BBCC44);
  endtask

  task automatic t_own_wait();
    spec_store(16'h0080, 32'h0000_0080, 4'hF);
    spec_store(16'h0090, 32'h0000_0090, 4'hF);
    spec_commit = 1'b1;
    st_spec = 1'b1;
    #1;
    check("R10 stall with commit high", st_ready, 1'b0);
    tick();
    spec_commit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R5 no drain before ownership", dr_valid, 1'b0);
      check("R10 stall while waiting", st_ready, 1'b0);
      tick();
    end
    grant(14'h0020);
    check("R5 partial grant still waits", dr_valid, 1'b0);
    tick();
    check("R5 partial grant still waits", dr_valid, 1'b0);
    gnt_valid = 1'b1; gnt_line = 14'h0024;
    tick();
    gnt_valid = 1'b0;
    check("R5 drain not before next edge", dr_valid, 1'b0);
    tick();
    check("R5 drain starts", dr_valid, 1'b1);
    check("R6 first beat addr", dr_addr, 16'h0080);
    dr_ready = 1'b0;
    pulse_abort();
    check("R8 abort ignored in drain", dr_valid, 1'b1);
    check("R6 held after back-pressure", dr_addr, 16'h0080);
    dr_ready = 1'b1;
    tick();
    check("R6 second beat", dr_addr, 16'h0090);
    check("R6 second beat last", dr_last, 1'b1);
    tick();
    check("R6 done after drain", commit_done, 1'b1);
    check("R8 no miss from ignored abort", miss_valid, 1'b0);
  endtask

  task automatic t_backpressure();
    spec_store(16'h0400, 32'h4, 4'hF);
    spec_store(16'h0404, 32'h5, 4'hF);
    spec_store(16'h0408, 32'h6, 4'hF);
    grant(14'h0100); grant(14'h0101); grant(14'h0102);
    run_commit(1'b1);
    check("R6 bp beat count", got_n, 3);
    check("R6 bp order", {got_a[0], got_a[1], got_a[2]}, {16'h0400, 16'h0404, 16'h0408});
  endtask

  task automatic t_abort();
    spec_store(16'h0500, 32'h7, 4'hF);
    spec_store(16'h0600, 32'h8, 4'hF);
    pulse_abort();
    check("R8 abort reports no miss", miss_valid, 1'b0);
    run_commit(1'b0);
    check("R8 abort left nothing", got_n, 0);
  endtask

  task automatic t_full();
    spec_store(16'h0700, 32'h1, 4'hF);
    spec_store(16'h0704, 32'h2, 4'hF);
    spec_store(16'h0708, 32'h3, 4'hF);
    spec_store(16'h070C, 32'h4, 4'hF);
    spec_store(16'h0700, 32'h9, 4'h1);
    check("R7 merge into full is not overflow", miss_valid, 1'b0);
    st_valid = 1'b1; st_spec = 1'b1; st_addr = 16'h0710;
    #1;
    check("R7 overflowing store consumed", st_ready, 1'b1);
    tick();
    st_valid = 1'b0;
    check("R7 overflow miss", miss_valid, 1'b1);
    check("R7 overflow cause", miss_cause, 1'b0);
    run_commit(1'b0);
    check("R7 entries discarded", got_n, 0);
  endtask

  task automatic t_snoop();
    spec_store(16'h0100, 32'h5, 4'hF);
    snoop(14'h0041);
    check("R9 unrelated snoop no miss", miss_valid, 1'b0);
    snoop(14'h0040);
    check("R9 conflict miss", miss_valid, 1'b1);
    check("R9 conflict cause", miss_cause, 1'b1);
    run_commit(1'b0);
    check("R9 conflict discarded", got_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_hidden_order();
    t_merge();
    t_own_wait();
    t_backpressure();
    t_abort();
    t_full();
    t_snoop();
    run_commit(1'b0);
    check("R6 empty commit no beats", got_n, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule